// File: doc/BRIEF.md
# BAR Address Window Decoder

This block sits beside a device's configuration header. It holds one system address window for each of the device's base address registers. Each window is built from the base the host programs, plus a fixed offset that moves I/O BARs into the platform's I/O aperture and memory BARs into its memory aperture. Each window has a size fixed by a parameter. A lookup request carries a system address. One cycle later the block answers whether the address falls in an active window, which BAR owns it, and the byte offset inside that region.

Each window is a two-state machine. In state `WIN_OFF` the window is unmapped and never matches. In state `WIN_ON` the window is mapped and matches its range. A qualifying BAR write takes the transition MAP (`WIN_OFF` to `WIN_ON`) or MOVE (`WIN_ON` to `WIN_ON`, new base). Any other cycle takes HOLD. No transition leads back to `WIN_OFF` except reset. A write is ignored in three cases:
- it is an all-ones sizing probe;
- its value is zero once the flag bits are cleared;
- it names a BAR index that does not exist.

Top module: `bar_window_decoder`

## Requirements
- R1: After reset every window is in WIN_OFF, `rsp_valid` is 0, and no lookup reports a hit.
- R2: A write to an I/O BAR (its bit set in `BAR_IS_IO`) maps the window at (`wr_data` with bit 0 cleared) + `IO_APERTURE`.
- R3: A write to a memory BAR maps the window at (`wr_data` with bits [1:0] cleared) + `MEM_APERTURE`.
- R4: A write whose value is zero after clearing the flag bits leaves that window's state and base unchanged.
- R5: A write of 32'hFFFF_FFFF (sizing probe) leaves that window's state and base unchanged.
- R6: Writing a new base to a mapped BAR moves its window, and the window keeps the same size. Addresses that only the old range covered stop hitting.
- R7: A window hits when base <= address < base + size. A window of size 0 never hits.
- R8: When several windows match, `rsp_bar` reports the lowest BAR index.
- R9: `rsp_off` equals the lookup address minus the base of the reported window.
- R10: A request on `lk_req` gives `rsp_valid` on the next cycle. A lookup in the same cycle as a BAR write sees the mapping from before that write. Lookups from the next cycle on see the new mapping.
- R11: A write with `wr_bar` >= `NUM_BARS` changes no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | BAR write strobe |
| wr_bar | input | 3 | Index of the BAR written |
| wr_data | input | 32 | Value written to the BAR |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 40 | System address to decode |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Address falls in an active window |
| rsp_bar | output | 3 | Index of the matching BAR |
| rsp_off | output | 40 | Offset inside the matching region |

## Verification
A BAR write and a lookup can arrive in the same cycle, and the lookup must then decode against the old mapping. The bench drives both in one cycle for two cases. In the first, the write maps a fresh I/O window over the looked-up address. In the second, the write moves a memory window away from it. The bench expects the pre-write answer for that cycle and the post-write answer from the lookup that follows.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    typedef enum logic {
        WIN_OFF = 1'b0,
        WIN_ON  = 1'b1
    } win_state_e;
endpackage

// File: rtl/bwd_window.sv
module bwd_window
    import bwd_pkg::*;
#(
    parameter int              ADDR_W   = 40,
    parameter int              DATA_W   = 32,
    parameter bit              IS_IO    = 1'b0,
    parameter logic [ADDR_W-1:0] SIZE   = '0,
    parameter logic [ADDR_W-1:0] APT_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              match,
    output logic [ADDR_W-1:0] off
);
    localparam int PAD_W = ADDR_W - DATA_W;

    win_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [DATA_W-1:0] field;
    logic              probe, take;
    logic [ADDR_W:0]   limit;

    always_comb begin
        field = wr_data;
        if (IS_IO) field[0]   = 1'b0;
        else       field[1:0] = 2'b00;
        probe = &wr_data;
        take  = wr_sel && !probe && (|field);
    end

    // next-state: MAP, MOVE, HOLD
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        unique case (state_q)
            WIN_OFF: if (take) begin
                state_d = WIN_ON;
                base_d  = {{PAD_W{1'b0}}, field} + APT_OFS;
            end
            WIN_ON: if (take) begin
                base_d  = {{PAD_W{1'b0}}, field} + APT_OFS;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_OFF;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
        end
    end

    always_comb begin
        limit = {1'b0, base_q} + {1'b0, SIZE};
        match = (state_q == WIN_ON) && (lk_addr >= base_q) && ({1'b0, lk_addr} < limit);
        off   = lk_addr - base_q;
    end

    p_probe_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (&wr_data)) |=> ($stable(base_q) && $stable(state_q)));
    p_zero_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (wr_data[DATA_W-1:2] == '0) && (IS_IO ? !wr_data[1] : 1'b1))
        |=> ($stable(base_q) && $stable(state_q)));
    p_stays_mapped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_ON) |=> (state_q == WIN_ON));
endmodule

// File: rtl/bwd_prio.sv
module bwd_prio #(
    parameter int N      = 6,
    parameter int ADDR_W = 40,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]        match,
    input  logic [N*ADDR_W-1:0] offs,
    output logic                any,
    output logic [IDX_W-1:0]    idx,
    output logic [ADDR_W-1:0]   off
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        off = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
                off = offs[i*ADDR_W +: ADDR_W];
            end
        end
    end

    always_comb begin
        if (any) begin
            p_lowest_wins_r8: assert (match[idx] &&
                ((match & ((N'(1) << idx) - N'(1))) == '0));
        end
    end
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder #(
    parameter int NUM_BARS = 6,
    parameter int ADDR_W   = 40,
    parameter int DATA_W   = 32,
    parameter logic [ADDR_W-1:0] IO_APERTURE  = 40'h01_0000_0000,
    parameter logic [ADDR_W-1:0] MEM_APERTURE = 40'h02_0000_0000,
    parameter logic [NUM_BARS-1:0] BAR_IS_IO  = 6'b000011,
    parameter logic [NUM_BARS*ADDR_W-1:0] BAR_SIZES = {
        40'h0, 40'h10_0000, 40'h1000, 40'h1000, 40'h40, 40'h100},
    localparam int IDX_W = $clog2(NUM_BARS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_bar,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_bar,
    output logic [ADDR_W-1:0] rsp_off
);
    logic [NUM_BARS-1:0]        match;
    logic [NUM_BARS*ADDR_W-1:0] offs;
    logic                       any;
    logic [IDX_W-1:0]           idx;
    logic [ADDR_W-1:0]          off;

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_win
        bwd_window #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .IS_IO  (BAR_IS_IO[i]),
            .SIZE   (BAR_SIZES[i*ADDR_W +: ADDR_W]),
            .APT_OFS(BAR_IS_IO[i] ? IO_APERTURE : MEM_APERTURE)
        ) u_win (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_sel (wr_en && (wr_bar == IDX_W'(i))),
            .wr_data(wr_data),
            .lk_addr(lk_addr),
            .match  (match[i]),
            .off    (offs[i*ADDR_W +: ADDR_W])
        );
    end

    bwd_prio #(.N(NUM_BARS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_prio (
        .match(match),
        .offs (offs),
        .any  (any),
        .idx  (idx),
        .off  (off)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_bar   <= '0;
            rsp_off   <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && any;
            rsp_bar   <= (lk_req && any) ? idx : '0;
            rsp_off   <= (lk_req && any) ? off : '0;
        end
    end

    p_resp_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    p_hit_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);
    p_bar_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_bar < IDX_W'(NUM_BARS)));
endmodule

// File: tb/bar_window_decoder_test.sv
module bar_window_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;
    localparam logic [39:0] IO_APT  = 40'h01_0000_0000;
    localparam logic [39:0] MEM_APT = 40'h02_0000_0000;
    localparam logic [5:0]  IS_IO   = 6'b000011;
    localparam logic [NB*40-1:0] SIZES = {
        40'h0, 40'h10_0000, 40'h1000, 40'h1000, 40'h40, 40'h100};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_bar = '0;
    logic [31:0] wr_data = '0;
    logic        lk_req = 1'b0;
    logic [39:0] lk_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [2:0]  rsp_bar;
    logic [39:0] rsp_off;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bar_window_decoder #(
        .NUM_BARS(NB), .ADDR_W(40), .DATA_W(32),
        .IO_APERTURE(IO_APT), .MEM_APERTURE(MEM_APT),
        .BAR_IS_IO(IS_IO), .BAR_SIZES(SIZES)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bar(wr_bar),
        .wr_data(wr_data), .lk_req(lk_req), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bar(rsp_bar),
        .rsp_off(rsp_off)
    );

    typedef struct {
        logic        hit;
        logic [2:0]  bar;
        logic [39:0] off;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [39:0] m_base [NB];
    bit          m_on   [NB];

    function automatic exp_t model_look(logic [39:0] a, string tag);
        exp_t e;
        e.hit = 1'b0; e.bar = '0; e.off = '0; e.tag = tag;
        for (int i = 0; i < NB; i++) begin
            logic [40:0] lim;
            lim = {1'b0, m_base[i]} + {1'b0, SIZES[i*40 +: 40]};
            if (!e.hit && m_on[i] && a >= m_base[i] && {1'b0, a} < lim) begin
                e.hit = 1'b1; e.bar = 3'(i); e.off = a - m_base[i];
            end
        end
        return e;
    endfunction

    function automatic void model_write(logic [2:0] b, logic [31:0] d);
        logic [31:0] f;
        if (b >= 3'(NB) || d == 32'hFFFF_FFFF) return;
        f = IS_IO[b] ? (d & ~32'h1) : (d & ~32'h3);
        if (f == 0) return;
        m_base[b] = {8'h0, f} + (IS_IO[b] ? IO_APT : MEM_APT);
        m_on[b] = 1'b1;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic bar_write(logic [2:0] b, logic [31:0] d);
        model_write(b, d);
        wr_en = 1'b1; wr_bar = b; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(logic [39:0] a, string tag);
        sb.push_back(model_look(a, tag));
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // R10: write and lookup in the same cycle; expectation uses old mapping
    task automatic write_and_look(logic [2:0] b, logic [31:0] d, logic [39:0] a, string tag);
        sb.push_back(model_look(a, tag));
        model_write(b, d);
        wr_en = 1'b1; wr_bar = b; wr_data = d;
        lk_req = 1'b1; lk_addr = a;
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b0;
    endtask

    // monitor: pops the scoreboard when a response appears
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected response", 64'(rsp_valid), 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_hit == e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
                if (e.hit && rsp_hit) begin
                    check(rsp_bar == e.bar, {e.tag, " bar"}, 64'(rsp_bar), 64'(e.bar));
                    check(rsp_off == e.off, {e.tag, " off"}, 64'(rsp_off), 64'(e.off));
                end
            end
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 1, 0);
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_base[i] = '0; m_on[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 idle rsp_valid", 64'(rsp_valid), 64'h0);
        lookup(IO_APT, "R1 io aperture after reset");
        lookup(MEM_APT + 40'h5000, "R1 mem after reset");

        bar_write(3'd0, 32'h0000_1201);
        lookup(40'h01_0000_1200, "R2 io base");
        lookup(40'h01_0000_12FF, "R7 io last byte");
        lookup(40'h01_0000_1300, "R7 io past end");
        lookup(40'h01_0000_11FF, "R7 io below base");

        bar_write(3'd2, 32'h0000_5003);
        lookup(40'h02_0000_5004, "R3 R9 mem offset");
        bar_write(3'd3, 32'h0000_5800);
        lookup(40'h02_0000_5900, "R8 overlap lowest");
        lookup(40'h02_0000_6000, "R9 bar3 only");

        bar_write(3'd2, 32'hFFFF_FFFF);
        lookup(40'h02_0000_5004, "R5 probe ignored");
        bar_write(3'd2, 32'h0000_0003);
        lookup(40'h02_0000_5004, "R4 mem masked zero");
        bar_write(3'd0, 32'h0000_0001);
        lookup(40'h01_0000_1210, "R4 io masked zero");

        bar_write(3'd7, 32'h0000_9000);
        lookup(40'h02_0000_9000, "R11 bad index");

        bar_write(3'd2, 32'h0000_7000);
        lookup(40'h02_0000_5004, "R6 old range gone");
        lookup(40'h02_0000_7010, "R6 new range");

        bar_write(3'd5, 32'h0000_A000);
        lookup(40'h02_0000_A000, "R7 size zero");
        bar_write(3'd4, 32'h0010_0000);
        lookup(40'h02_001F_FFFF, "R9 large window end");

        write_and_look(3'd1, 32'h0000_0300, 40'h01_0000_0300, "R10 same-cycle map old");
        lookup(40'h01_0000_0300, "R10 map visible next");
        write_and_look(3'd2, 32'h0000_B000, 40'h02_0000_7010, "R10 same-cycle move old");
        lookup(40'h02_0000_7010, "R10 move visible next");
        lookup(40'h02_0000_B020, "R6 moved window");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R10 all responses seen", 64'(sb.size()), 64'h0);
        done = 1'b1;
        finish_run();
    end
endmodule